// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This unit tracks how error-prone a CAN node has been. It keeps one counter for
receive errors and one for transmit errors. It changes them only when the frame
sequencer sends a single-cycle command strobe, and from the counter values it
derives the node's fault state. The unit does not detect bus errors itself. It
only reacts to strobes that tell it an error happened or that a frame
completed cleanly.

The frame sequencer reads the two flag outputs to choose its behaviour. When the
passive flag is set, the sequencer uses passive error flags. When the bus-off
flag is set, the sequencer stays off the bus. While the node is bus-off, the
sequencer pulses an idle indication each time it sees a run of eleven
recessive bits. After enough of these pulses, the unit clears both counters and
returns the node to full participation.

The state machine has three states:

| State | Code | Meaning |
|-------|------|---------|
| `FC_ACTIVE` | `2'b00` | Error active. Both counters are below the passive threshold. |
| `FC_PASSIVE` | `2'b01` | Error passive. At least one counter is at or above the threshold, and the node is not bus-off. |
| `FC_BUSOFF` | `2'b10` | Bus-off. The transmit counter went past the bus-off limit. |

The transitions are:

| Transition | Condition |
|------------|-----------|
| `go_passive` | ACTIVE to PASSIVE: the next value of either counter is 128 or more. |
| `go_active` | PASSIVE to ACTIVE: the next values of both counters are below 128. |
| `go_busoff` | ACTIVE or PASSIVE to BUSOFF: the next transmit count is above 255. |
| `recover` | BUSOFF to ACTIVE: the 128th idle indication arrives while the node is bus-off. |
| `stay` | None of the above applies. |

Top module: `can_fault_conf`

## Requirements
- R1: While `rst` is high at a clock edge, both counters go to 0 and `node_state` goes to `2'b00` (active), with both flags low.
- R2: A `tx_err_inc` strobe adds 8 to the transmit counter.
- R3: A `rx_err_inc` strobe adds 1 to the receive counter. If `err_heavy` is high in the same cycle, it adds 8 instead. The receive counter saturates at 255.
- R4: A `tx_ok_dec` strobe subtracts 1 from the transmit counter, and a `rx_ok_dec` strobe subtracts 1 from the receive counter. Neither counter goes below 0.
- R5: When an increment and a decrement strobe reach the same counter in one cycle, only the increment applies. Strobes to the two different counters in one cycle both apply.
- R6: Outside bus-off, `node_state` is `2'b01` with `is_passive` high when either counter is at least 128. It is `2'b00` with `is_passive` low when both counters are below 128.
- R7: When the transmit counter exceeds 255, `node_state` becomes `2'b10` and `is_bus_off` goes high. The receive counter never causes bus-off, not even at 255.
- R8: While the node is bus-off, all counter strobes are ignored and both counter values stay unchanged.
- R9: While the node is bus-off, the 128th `idle11_seen` pulse clears both counters and returns the state to `2'b00`. Pulses received outside bus-off do not count toward the 128.
- R10: Every output reflects a strobe at the first clock edge after the cycle in which the strobe is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_err_inc | input | 1 | Strobe: transmit error seen |
| rx_err_inc | input | 1 | Strobe: receive error seen |
| err_heavy | input | 1 | Selects the larger step (8) for a receive error |
| tx_ok_dec | input | 1 | Strobe: frame transmitted successfully |
| rx_ok_dec | input | 1 | Strobe: frame received successfully |
| idle11_seen | input | 1 | Strobe: eleven recessive bits observed |
| tx_err_cnt | output | TX_W (9) | Transmit error counter |
| rx_err_cnt | output | RX_W (8) | Receive error counter |
| node_state | output | 2 | Fault state code: 00 active, 01 passive, 10 bus-off |
| is_passive | output | 1 | High in the passive state |
| is_bus_off | output | 1 | High in the bus-off state |

## Verification
The counters and the state register are updated at the same clock edge. The state is computed from the counters' next values, so a strobe presented in one cycle shows on every output after exactly one rising edge. That holds even when the strobe moves the node across a threshold or completes recovery. The bench drives strobes just after a falling edge and checks all outputs at the following falling edge. It compares them against a behavioural model that is advanced once per rising edge, so every comparison falls in the cycle where the result is due.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fc_state_e;
endpackage

// File: rtl/fc_err_counter.sv
// Saturating or plain up/down error counter, driven by strobes.
module fc_err_counter #(
    parameter int W        = 8,
    parameter bit SATURATE = 1'b1,
    parameter int MAX_VAL  = 255
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         hold,
    input  logic         inc,
    input  logic         dec,
    input  logic [W-1:0] step,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d
);
    localparam logic [W:0] SAT_MAX = (W+1)'(MAX_VAL);

    logic [W:0]   sum;
    logic [W-1:0] inc_val;

    assign sum = {1'b0, cnt_q} + {1'b0, step};

    generate
        if (SATURATE) begin : g_sat
            assign inc_val = (sum > SAT_MAX) ? SAT_MAX[W-1:0] : sum[W-1:0];
        end else begin : g_wrap
            assign inc_val = sum[W-1:0];
        end
    endgenerate

    // The increment wins over a decrement in the same cycle.
    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (!hold) begin
            if (inc) begin
                cnt_d = inc_val;
            end else if (dec && (cnt_q != '0)) begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/fc_recovery.sv
// Counts idle indications while the node is bus-off.
module fc_recovery #(
    parameter int RECOV_N = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic in_busoff,
    input  logic idle,
    output logic done
);
    localparam int RW = (RECOV_N > 1) ? $clog2(RECOV_N) : 1;
    localparam logic [RW-1:0] LAST = RW'(RECOV_N - 1);

    logic [RW-1:0] cnt_q;

    assign done = in_busoff && idle && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !in_busoff || done) begin
            cnt_q <= '0;
        end else if (idle) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fc_state_fsm.sv
// Fault-state machine, computed from the counters' next values.
module fc_state_fsm
    import fc_pkg::*;
#(
    parameter int TX_W         = 9,
    parameter int RX_W         = 8,
    parameter int PASSIVE_TH   = 128,
    parameter int BUSOFF_LIMIT = 255
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TX_W-1:0] tx_nxt,
    input  logic [RX_W-1:0] rx_nxt,
    input  logic            recov_done,
    output fc_state_e       state_q,
    output logic            passive_o,
    output logic            busoff_o
);
    localparam logic [TX_W-1:0] TX_PASS = TX_W'(PASSIVE_TH);
    localparam logic [RX_W-1:0] RX_PASS = RX_W'(PASSIVE_TH);
    localparam logic [TX_W-1:0] TX_OFF  = TX_W'(BUSOFF_LIMIT);

    fc_state_e state_d;
    logic      over_pass;

    assign over_pass = (tx_nxt >= TX_PASS) || (rx_nxt >= RX_PASS);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_ACTIVE, FC_PASSIVE: begin
                if (tx_nxt > TX_OFF) begin
                    state_d = FC_BUSOFF;
                end else if (over_pass) begin
                    state_d = FC_PASSIVE;
                end else begin
                    state_d = FC_ACTIVE;
                end
            end
            FC_BUSOFF: begin
                if (recov_done) begin
                    state_d = FC_ACTIVE;
                end
            end
            default: state_d = FC_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FC_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        passive_o = (state_q == FC_PASSIVE);
        busoff_o  = (state_q == FC_BUSOFF);
    end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
    import fc_pkg::*;
#(
    parameter int TX_W          = 9,
    parameter int RX_W          = 8,
    parameter int TX_STEP       = 8,
    parameter int RX_STEP       = 1,
    parameter int RX_HEAVY_STEP = 8,
    parameter int PASSIVE_TH    = 128,
    parameter int BUSOFF_LIMIT  = 255,
    parameter int RX_MAX        = 255,
    parameter int RECOV_N       = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tx_err_inc,
    input  logic            rx_err_inc,
    input  logic            err_heavy,
    input  logic            tx_ok_dec,
    input  logic            rx_ok_dec,
    input  logic            idle11_seen,
    output logic [TX_W-1:0] tx_err_cnt,
    output logic [RX_W-1:0] rx_err_cnt,
    output logic [1:0]      node_state,
    output logic            is_passive,
    output logic            is_bus_off
);
    localparam logic [TX_W-1:0] TX_STEP_V  = TX_W'(TX_STEP);
    localparam logic [RX_W-1:0] RX_LIGHT_V = RX_W'(RX_STEP);
    localparam logic [RX_W-1:0] RX_HEAVY_V = RX_W'(RX_HEAVY_STEP);

    fc_state_e       state;
    logic            recov_done;
    logic            in_busoff;
    logic [TX_W-1:0] tx_nxt;
    logic [RX_W-1:0] rx_nxt;
    logic [RX_W-1:0] rx_step;

    assign in_busoff = (state == FC_BUSOFF);
    assign rx_step   = err_heavy ? RX_HEAVY_V : RX_LIGHT_V;

    fc_err_counter #(
        .W        (TX_W),
        .SATURATE (1'b0),
        .MAX_VAL  ((1 << TX_W) - 1)
    ) u_tx_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (recov_done),
        .hold  (in_busoff),
        .inc   (tx_err_inc),
        .dec   (tx_ok_dec),
        .step  (TX_STEP_V),
        .cnt_q (tx_err_cnt),
        .cnt_d (tx_nxt)
    );

    fc_err_counter #(
        .W        (RX_W),
        .SATURATE (1'b1),
        .MAX_VAL  (RX_MAX)
    ) u_rx_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (recov_done),
        .hold  (in_busoff),
        .inc   (rx_err_inc),
        .dec   (rx_ok_dec),
        .step  (rx_step),
        .cnt_q (rx_err_cnt),
        .cnt_d (rx_nxt)
    );

    fc_recovery #(
        .RECOV_N (RECOV_N)
    ) u_recov (
        .clk       (clk),
        .rst       (rst),
        .in_busoff (in_busoff),
        .idle      (idle11_seen),
        .done      (recov_done)
    );

    fc_state_fsm #(
        .TX_W         (TX_W),
        .RX_W         (RX_W),
        .PASSIVE_TH   (PASSIVE_TH),
        .BUSOFF_LIMIT (BUSOFF_LIMIT)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tx_nxt     (tx_nxt),
        .rx_nxt     (rx_nxt),
        .recov_done (recov_done),
        .state_q    (state),
        .passive_o  (is_passive),
        .busoff_o   (is_bus_off)
    );

    assign node_state = state;
endmodule

// File: rtl/fc_checker.sv
module fc_checker
    import fc_pkg::*;
#(
    parameter int TX_W         = 9,
    parameter int RX_W         = 8,
    parameter int TX_STEP      = 8,
    parameter int PASSIVE_TH   = 128,
    parameter int BUSOFF_LIMIT = 255
) (
    input logic            clk,
    input logic            rst,
    input logic            tx_err_inc,
    input logic            tx_ok_dec,
    input logic            idle11_seen,
    input logic [TX_W-1:0] tx_err_cnt,
    input logic [RX_W-1:0] rx_err_cnt,
    input logic [1:0]      node_state
);
    localparam logic [TX_W-1:0] TX_PASS = TX_W'(PASSIVE_TH);
    localparam logic [RX_W-1:0] RX_PASS = RX_W'(PASSIVE_TH);
    localparam logic [TX_W-1:0] TX_OFF  = TX_W'(BUSOFF_LIMIT);

    // R2
    tx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (node_state != FC_BUSOFF && tx_err_inc)
        |=> tx_err_cnt == TX_W'($past(tx_err_cnt) + TX_W'(TX_STEP)));

    // R4
    tx_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (node_state != FC_BUSOFF && tx_ok_dec && !tx_err_inc && tx_err_cnt == '0)
        |=> tx_err_cnt == '0);

    // R6
    active_code_chk: assert property (@(posedge clk) disable iff (rst)
        (node_state == FC_ACTIVE) |-> (tx_err_cnt < TX_PASS && rx_err_cnt < RX_PASS));

    // R6
    passive_code_chk: assert property (@(posedge clk) disable iff (rst)
        (node_state == FC_PASSIVE)
        |-> ((tx_err_cnt >= TX_PASS || rx_err_cnt >= RX_PASS) && tx_err_cnt <= TX_OFF));

    // R7
    busoff_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_err_cnt > TX_OFF) |-> node_state == FC_BUSOFF);

    // R8
    busoff_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (node_state == FC_BUSOFF && !idle11_seen)
        |=> ($stable(tx_err_cnt) && $stable(rx_err_cnt)));

    // R9
    recover_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (node_state == FC_BUSOFF)
        |=> (node_state == FC_BUSOFF
             || (node_state == FC_ACTIVE && tx_err_cnt == '0 && rx_err_cnt == '0)));
endmodule

bind can_fault_conf fc_checker #(
    .TX_W         (TX_W),
    .RX_W         (RX_W),
    .TX_STEP      (TX_STEP),
    .PASSIVE_TH   (PASSIVE_TH),
    .BUSOFF_LIMIT (BUSOFF_LIMIT)
) u_fc_checker (
    .clk         (clk),
    .rst         (rst),
    .tx_err_inc  (tx_err_inc),
    .tx_ok_dec   (tx_ok_dec),
    .idle11_seen (idle11_seen),
    .tx_err_cnt  (tx_err_cnt),
    .rx_err_cnt  (rx_err_cnt),
    .node_state  (node_state)
);

// File: tb/test_can_fault_conf.sv
`timescale 1ns/1ps
module test_can_fault_conf;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_err_inc = 1'b0, rx_err_inc = 1'b0, err_heavy = 1'b0;
    logic       tx_ok_dec = 1'b0, rx_ok_dec = 1'b0, idle11_seen = 1'b0;
    logic [8:0] tx_err_cnt;
    logic [7:0] rx_err_cnt;
    logic [1:0] node_state;
    logic       is_passive, is_bus_off;

    int n_tests = 0;
    int n_fail  = 0;
    int m_tx = 0, m_rx = 0, m_st = 0, m_rec = 0;

    always #2.5 clk = ~clk;

    can_fault_conf i_can_fault_conf (
        .clk(clk), .rst(rst),
        .tx_err_inc(tx_err_inc), .rx_err_inc(rx_err_inc), .err_heavy(err_heavy),
        .tx_ok_dec(tx_ok_dec), .rx_ok_dec(rx_ok_dec), .idle11_seen(idle11_seen),
        .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt), .node_state(node_state),
        .is_passive(is_passive), .is_bus_off(is_bus_off)
    );

    task automatic compare(input string tag);
        int exp_code;
        exp_code = m_st;
        n_tests++;
        if (int'(tx_err_cnt) != m_tx || int'(rx_err_cnt) != m_rx ||
            int'(node_state) != exp_code || is_passive != (m_st == 1) ||
            is_bus_off != (m_st == 2)) begin
            n_fail++;
            $display("FAIL %s: got tx=%0d rx=%0d st=%0d pas=%0b off=%0b, expected tx=%0d rx=%0d st=%0d pas=%0b off=%0b",
                     tag, tx_err_cnt, rx_err_cnt, node_state, is_passive, is_bus_off,
                     m_tx, m_rx, m_st, (m_st == 1), (m_st == 2));
        end
    endtask

    // Behavioural model: advance one clock edge.
    task automatic model_edge(input bit ti, ri, hv, td, rd, id);
        if (m_st == 2) begin
            if (id) begin
                m_rec++;
                if (m_rec == 128) begin
                    m_tx = 0; m_rx = 0; m_st = 0; m_rec = 0;
                end
            end
        end else begin
            m_rec = 0;
            if (ti) m_tx += 8;
            else if (td && m_tx > 0) m_tx -= 1;
            if (ri) begin
                m_rx += hv ? 8 : 1;
                if (m_rx > 255) m_rx = 255;
            end else if (rd && m_rx > 0) m_rx -= 1;
            if (m_tx > 255) m_st = 2;
            else if (m_tx >= 128 || m_rx >= 128) m_st = 1;
            else m_st = 0;
        end
    endtask

    // Present strobes for one cycle, then check at the next falling edge.
    task automatic step(input bit ti, ri, hv, td, rd, id, input string tag);
        tx_err_inc = ti; rx_err_inc = ri; err_heavy = hv;
        tx_ok_dec = td; rx_ok_dec = rd; idle11_seen = id;
        @(posedge clk);
        model_edge(ti, ri, hv, td, rd, id);
        @(negedge clk);
        tx_err_inc = 0; rx_err_inc = 0; err_heavy = 0;
        tx_ok_dec = 0; rx_ok_dec = 0; idle11_seen = 0;
        compare(tag);
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare("R1 reset state");

        step(1,0,0,0,0,0, "R2 tx error +8");
        step(1,0,0,0,0,0, "R10 one-cycle latency");
        step(0,1,0,0,0,0, "R3 rx error +1");
        step(0,1,1,0,0,0, "R3 rx heavy +8");
        step(0,0,0,1,1,0, "R4 both decrement");
        step(1,0,0,1,0,0, "R5 tx inc beats dec");
        step(0,1,0,0,1,0, "R5 rx inc beats dec");
        step(1,1,0,0,0,0, "R5 both counters same cycle");
        for (int i = 0; i < 40; i++) step(0,0,0,1,1,0, "R4 decrement to floor");
        step(0,0,0,1,1,0, "R4 no underflow");

        for (int i = 0; i < 40; i++) step(0,1,1,0,0,0, "R3 rx climb");
        step(0,1,0,0,0,0, "R3 rx saturates at 255");
        step(0,1,1,0,0,0, "R7 rx at 255 no busoff");
        step(0,0,0,0,0,0, "R6 passive from rx");
        for (int i = 0; i < 130; i++) step(0,0,0,0,1,0, "R6 back to active");

        for (int i = 0; i < 16; i++) step(1,0,0,0,0,0, "R6 tx reaches 128");
        step(0,0,0,1,0,0, "R6 tx 127 active");
        step(1,0,0,0,0,0, "R6 tx passive again");
        for (int i = 0; i < 16; i++) step(1,0,0,0,0,0, "R7 tx to busoff");
        step(1,1,1,1,1,0, "R8 strobes ignored");
        step(0,0,0,1,1,0, "R8 decrements ignored");
        for (int i = 0; i < 127; i++) step(0,0,0,0,0,1, "R9 recovery pending");
        step(0,0,0,0,0,1, "R9 recovery complete");

        for (int i = 0; i < 50; i++) step(0,0,0,0,0,1, "R9 idle outside busoff");
        for (int i = 0; i < 33; i++) step(1,0,0,0,0,0, "R7 second busoff");
        for (int i = 0; i < 127; i++) step(0,1,0,0,0,1, "R9 second recovery pending");
        step(1,0,0,0,0,1, "R9 second recovery");
        step(1,0,0,0,0,0, "R2 counting after recovery");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule